// File: doc/BRIEF.md
# Serial Clock-Configuration Register

This block is the digital receiving end of a three-wire configuration port for a frequency synthesizer. A host shifts a 24-bit frame in on a data line, one bit per rising edge of a serial clock. The host then raises a load line, which copies the frame into a holding register. The holding register drives the synthesizer's settings as decoded fields: a 7-bit reference divider, a 9-bit VCO divider, a 3-bit output divide select, a 2-bit auxiliary-output mode, a duty-cycle/TTL select bit and a 2-bit crystal load code.

The three port lines are not used as clocks. They are sampled in the system clock domain through two-flop synchronizers, and their edges are found by comparison with the previous synchronized value. While the load line is high the holding register is transparent: every serial clock edge shifts a bit in and also updates the live outputs on that same edge. A one-cycle `cfg_updated` pulse marks every change of the holding register, so downstream logic can restart a lock timer.

Top module: `cfg_serial_port`

## Requirements
- R1: While reset is asserted, the holding register takes the 24-bit default word 0x230406. In frame order this is crystal load 00, TTL 1, auxiliary mode 00, divide select 011, VCO divider 8 and reference divider 6. The shift register clears to zero and `cfg_updated` is low.
- R2: Each synchronized rising edge of `cfg_sclk` shifts `cfg_data` into bit 0 of the 24-bit shift register, so the first bit of a frame ends up in bit 23. The frame fields from bit 23 down to bit 0 are: crystal load [23:22], TTL [21], auxiliary mode [20:19], divide select [18:16], VCO divider [15:7] and reference divider [6:0].
- R3: While the synchronized `cfg_strobe` is low, shifting leaves all configuration outputs unchanged.
- R4: A rising edge of `cfg_strobe` copies the shift register into the holding register. A pin transition sampled at one system clock edge takes effect at the second edge after that one.
- R5: The frame 0x318A3B, sent as bytes 00110001 10001010 00111011 and then strobed, decodes to reference divider 59, VCO divider 276, divide select 001, auxiliary mode 10, TTL 1 and crystal load 00.
- R6: While the synchronized `cfg_strobe` is high, each `cfg_sclk` rising edge loads the holding register with the shift register value after that edge's shift.
- R7: `cfg_updated` is high for exactly one system clock in every cycle in which the holding register changes, and stays low otherwise. A strobe that reloads identical contents gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_data | input | 1 | Serial data line |
| cfg_sclk | input | 1 | Serial shift clock, sampled as data |
| cfg_strobe | input | 1 | Load line: a rising edge latches the frame; held high it makes the register transparent |
| ref_div | output | 7 | Reference divider word |
| vco_div | output | 9 | VCO divider word |
| out_div_sel | output | 3 | Output divide select |
| clk2_mode | output | 2 | Auxiliary clock output function |
| ttl_duty | output | 1 | Duty-cycle / TTL level select |
| xtal_load | output | 2 | Crystal load capacitance code |
| cfg_updated | output | 1 | One-cycle pulse when the configuration changes |

## Verification
The hardest situation to reach from the ports is the transparent mode. There the load line is already high, so each serial clock edge both shifts and rewrites the live outputs. An edge where the strobe and the serial clock rise in the same synchronized cycle is equally hard to reach. The stimulus first loads a known frame, then holds the strobe high and clocks single bits while the outputs are compared after every bit. It also re-strobes unchanged contents to show that no update pulse appears. A behavioural model fed by the pin history checks the outputs and the pulse on every clock.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter logic [23:0] RESET_WORD = 24'h230406
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_data,
  input  logic       cfg_sclk,
  input  logic       cfg_strobe,
  output logic [6:0] ref_div,
  output logic [8:0] vco_div,
  output logic [2:0] out_div_sel,
  output logic [1:0] clk2_mode,
  output logic       ttl_duty,
  output logic [1:0] xtal_load,
  output logic       cfg_updated
);
  localparam int FRAME_BITS = 24;

  logic [1:0] sclk_sync, strb_sync, data_sync;
  logic       sclk_prev, strb_prev;
  logic [FRAME_BITS-1:0] shreg, latch;

  wire sclk_rise  = sclk_sync[1] & ~sclk_prev;
  wire strb_level = strb_sync[1];
  wire strb_rise  = strb_sync[1] & ~strb_prev;
  wire bit_in     = data_sync[1];

  wire [FRAME_BITS-1:0] shift_next = sclk_rise ? {shreg[FRAME_BITS-2:0], bit_in} : shreg;
  wire                  load       = strb_rise | (strb_level & sclk_rise);
  wire [FRAME_BITS-1:0] latch_next = load ? shift_next : latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sync   <= '0;
      strb_sync   <= '0;
      data_sync   <= '0;
      sclk_prev   <= 1'b0;
      strb_prev   <= 1'b0;
      shreg       <= '0;
      latch       <= RESET_WORD;
      cfg_updated <= 1'b0;
    end else begin
      sclk_sync   <= {sclk_sync[0], cfg_sclk};
      strb_sync   <= {strb_sync[0], cfg_strobe};
      data_sync   <= {data_sync[0], cfg_data};
      sclk_prev   <= sclk_sync[1];
      strb_prev   <= strb_sync[1];
      shreg       <= shift_next;
      latch       <= latch_next;
      cfg_updated <= (latch_next != latch);
    end
  end

  assign xtal_load   = latch[23:22];
  assign ttl_duty    = latch[21];
  assign clk2_mode   = latch[20:19];
  assign out_div_sel = latch[18:16];
  assign vco_div     = latch[15:7];
  assign ref_div     = latch[6:0];
endmodule

module cfg_serial_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk_rise,
  input logic        strb_level,
  input logic        strb_rise,
  input logic        bit_in,
  input logic [23:0] shreg,
  input logic [23:0] latch,
  input logic        cfg_updated
);
  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> (shreg[0] == $past(bit_in)) && (shreg[23:1] == $past(shreg[22:0])));

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb_level |=> $stable(latch));

  // R4
  strobe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb_rise |=> latch == shreg);

  // R6
  transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_level && sclk_rise) |=> latch == shreg);

  // R7
  pulse_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_updated |-> latch != $past(latch));

  // R7
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_updated |-> $stable(latch));
endmodule

bind cfg_serial_port cfg_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .strb_level(strb_level),
  .strb_rise(strb_rise), .bit_in(bit_in), .shreg(shreg), .latch(latch),
  .cfg_updated(cfg_updated)
);

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam logic [23:0] DEF_WORD = 24'h230406;

  logic clk = 0, rst_n = 0, cfg_data = 0, cfg_sclk = 0, cfg_strobe = 0;
  logic [6:0] ref_div;
  logic [8:0] vco_div;
  logic [2:0] out_div_sel;
  logic [1:0] clk2_mode, xtal_load;
  logic ttl_duty, cfg_updated;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 0;

  cfg_serial_port dut (
    .clk(clk), .rst_n(rst_n), .cfg_data(cfg_data), .cfg_sclk(cfg_sclk),
    .cfg_strobe(cfg_strobe), .ref_div(ref_div), .vco_div(vco_div),
    .out_div_sel(out_div_sel), .clk2_mode(clk2_mode), .ttl_duty(ttl_duty),
    .xtal_load(xtal_load), .cfg_updated(cfg_updated)
  );

  always #10 clk = ~clk;

  wire [23:0] obs = {xtal_load, ttl_duty, clk2_mode, out_div_sel, vco_div, ref_div};

  // Behavioural model driven by the pin history (samples one, two, three edges old)
  logic [2:0] h1, h2, h3;  // {data, sclk, strobe}
  logic [23:0] m_sh, m_lat, m_old;
  logic m_upd;
  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; m_sh = 0; m_lat = DEF_WORD; m_upd = 0;
    end else begin
      m_old = m_lat;
      if (h2[1] && !h3[1]) begin
        m_sh = {m_sh[22:0], h2[2]};
        if (h2[0]) m_lat = m_sh;
      end
      if (h2[0] && !h3[0]) m_lat = m_sh;
      m_upd = (m_lat != m_old);
      h3 = h2; h2 = h1; h1 = {cfg_data, cfg_sclk, cfg_strobe};
    end
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R4 per-cycle outputs", obs, m_lat);
    check("R7 per-cycle update pulse", {23'd0, cfg_updated}, {23'd0, m_upd});
    if (cfg_updated) pulses++;
  end

  task automatic put_bit(input logic b);
    @(negedge clk) cfg_data = b;
    repeat (3) @(negedge clk);
    cfg_sclk = 1;
    repeat (3) @(negedge clk);
    cfg_sclk = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) put_bit(w[i]);
  endtask

  task automatic pulse_strobe();
    @(negedge clk) cfg_strobe = 1;
    repeat (5) @(negedge clk);
    cfg_strobe = 0;
    repeat (6) @(negedge clk);
  endtask

  logic [23:0] exp_w;

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 default word", obs, DEF_WORD);
    check("R1 ref_div", {17'd0, ref_div}, 24'd6);
    check("R1 vco_div", {15'd0, vco_div}, 24'd8);
    check("R1 out_div_sel", {21'd0, out_div_sel}, 24'd3);
    check("R1 ttl", {23'd0, ttl_duty}, 24'd1);
    check("R1 updated low", {23'd0, cfg_updated}, 24'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R3 shifting with strobe low leaves outputs alone
    shift_word(24'h318A3B);
    repeat (4) @(negedge clk);
    check("R3 outputs held", obs, DEF_WORD);

    // R4 / R5 strobe and decode
    pulses = 0;
    pulse_strobe();
    check("R5 ref_div", {17'd0, ref_div}, 24'd59);
    check("R5 vco_div", {15'd0, vco_div}, 24'd276);
    check("R5 out_div_sel", {21'd0, out_div_sel}, 24'd1);
    check("R5 clk2_mode", {22'd0, clk2_mode}, 24'd2);
    check("R5 ttl", {23'd0, ttl_duty}, 24'd1);
    check("R5 xtal_load", {22'd0, xtal_load}, 24'd0);
    check("R7 one pulse on change", pulses, 24'd1);

    // R7 identical reload gives no pulse
    pulses = 0;
    pulse_strobe();
    check("R7 no pulse on same contents", pulses, 24'd0);

    // R2 frame position
    shift_word(24'hC5A5F0);
    pulse_strobe();
    check("R2 frame bit order", obs, 24'hC5A5F0);

    // R6 transparent mode
    @(negedge clk) cfg_strobe = 1;
    repeat (6) @(negedge clk);
    exp_w = 24'hC5A5F0;
    put_bit(1'b1);
    exp_w = {exp_w[22:0], 1'b1};
    repeat (2) @(negedge clk);
    check("R6 transparent bit 1", obs, exp_w);
    put_bit(1'b0);
    exp_w = {exp_w[22:0], 1'b0};
    repeat (2) @(negedge clk);
    check("R6 transparent bit 0", obs, exp_w);
    cfg_strobe = 0;
    repeat (6) @(negedge clk);
    put_bit(1'b1);
    repeat (4) @(negedge clk);
    check("R3 no change after strobe low", obs, exp_w);

    // R1 reset again mid-run
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 reset reload", obs, DEF_WORD);
    check("R1 updated low in reset", {23'd0, cfg_updated}, 24'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule